// File: doc/BRIEF.md
# Stereo Audio Port Register and FIFO Controller

This block is the register face of a stereo serial audio port. A host reaches it through a plain register read/write port: seven word-aligned registers set up the link, its framing, its interrupt masking and its bit-clock divider. A single data address serves both directions, so a host write feeds the transmit queue and a host read drains the receive queue. The serial shifting engine sits outside the block. It takes transmit words through a pull request and hands back received words through a push request.

Each direction has a 16-deep, 32-bit queue. Each queue raises a service request whenever its fill level crosses a programmable threshold. The two error conditions are a transmit underrun and a receive overrun. Both are sticky until software writes a one to the matching bit of the clear register. A single interrupt line is formed from the status conditions and their mask bits. A soft-reset bit in the global control register empties both queues and drops both sticky flags for as long as it stays set.

Top module: `audio_port_ctrl`

## Requirements
- R1: After rst_n is held low, every writable register reads 0, irq is 0, and the status register (offset 0x0C) reads 0x99. In that value, bit 0 means transmit queue not full, bit 3 is the transmit service request, bit 4 is the receive service request and bit 7 means the link is off.
- R2: Only the defined bits of each register can be written, and every other bit reads 0. The masks are 0xFF0D for global control (0x00), 0x39 for format (0x04), 0x78 for interrupt mask (0x14) and the low DIV_W bits for the divider (0x60). The clear register (0x18) always reads 0.
- R3: A write to 0x80 pushes a word into the transmit queue while it holds fewer than 16 words, and a write to a full queue is dropped. Each tx_pull pops one word, in write order, and that word is shown on tx_word during the pull cycle. Status bit 0 is 1 unless the queue is full.
- R4: Each rx_push stores one word. A read of 0x80 returns the oldest stored word and removes it, and it returns 0 when the queue is empty. Status bit 1 is 1 while the receive queue holds a word.
- R5: Status bit 3 is 1 while the transmit fill level is less than or equal to global control bits 11:8.
- R6: Status bit 4 is 1 while the receive fill level is greater than or equal to global control bits 15:12.
- R7: A tx_pull while the transmit queue is empty sets status bit 5, and tx_word reads 0 in that cycle. The bit stays set until it is cleared.
- R8: An rx_push while the receive queue holds 16 words sets status bit 6, and the word is discarded.
- R9: Writing 1 to bit 5 or bit 6 of 0x18 clears the matching sticky flag, and zero bits have no effect. If a new error event occurs in the same cycle as its clear, the flag stays set.
- R10: While global control bit 3 is 1, both queues are emptied and both sticky flags are cleared.
- R11: Status bit 2 (busy) is 1 while enable (control bit 0) is 1 and frame_active is 1. Status bit 7 (off) is 1 while enable is 0 and frame_active is 0.
- R12: irq is 1 exactly when any of status bits 3 to 6 is 1 and the matching bit of the interrupt mask register is also 1.
- R13: The outputs mirror their register fields. link_en is control bit 0, bclk_out_en is control bit 2, fmt_msb_just is format bit 0, rec_off is format bit 3, play_off is format bit 4, loopback is format bit 5, and clk_div is the divider register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered on the read edge |
| tx_pull | input | 1 | Engine asks for the next transmit word |
| tx_word | output | 32 | Head of the transmit queue, or 0 if it is empty |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | 32 | Received word |
| frame_active | input | 1 | Engine is in the middle of a frame |
| link_en | output | 1 | Link enable |
| bclk_out_en | output | 1 | Bit clock driven by this side |
| fmt_msb_just | output | 1 | MSB-justified framing selected |
| rec_off | output | 1 | Recording disabled |
| play_off | output | 1 | Playback disabled |
| loopback | output | 1 | Loopback enabled |
| clk_div | output | DIV_W | Bit-clock divider value |
| irq | output | 1 | Masked interrupt |

## Verification
A register write takes effect after the edge that accepts it. The status word, the control outputs and irq all reflect that write in the following cycle. A read returns its value on reg_rdata one edge after the read strobe. Queue pushes, pops, flag changes and flush therefore show at the next edge, and tx_word is valid during the pull cycle itself. The bench drives every input at the falling edge and holds it for one cycle. It samples reg_rdata, irq and the control outputs at the next falling edge, and it checks tx_word just before the edge that consumes it.

// File: rtl/aud_pkg.sv
// Shared constants for the audio port controller: register offsets and
// status bit positions that software decodes. Assumes byte offsets.
package aud_pkg;
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_FMT   = 8'h04;
    localparam logic [7:0] OFF_STAT  = 8'h0C;
    localparam logic [7:0] OFF_MASK  = 8'h14;
    localparam logic [7:0] OFF_CLR   = 8'h18;
    localparam logic [7:0] OFF_DIV   = 8'h60;
    localparam logic [7:0] OFF_DATA  = 8'h80;

    localparam logic [15:0] CTRL_WMASK = 16'hFF0D;
    localparam logic [5:0]  FMT_WMASK  = 6'h39;
    localparam logic [6:0]  MASK_WMASK = 7'h78;

    localparam int ST_TNF = 0;
    localparam int ST_RNE = 1;
    localparam int ST_BSY = 2;
    localparam int ST_TRQ = 3;
    localparam int ST_RRQ = 4;
    localparam int ST_UR  = 5;
    localparam int ST_OVR = 6;
    localparam int ST_OFF = 7;
endpackage

// File: rtl/aud_fifo.sv
// Synchronous first-word-fall-through queue with a level count.
// Assumes DEPTH is a power of two and that the caller never pushes when
// full or pops when empty; flush has priority over push and pop.
module aud_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    // Storage write: data only, no reset needed.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wptr] <= din;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    assign dout  = mem[rptr];
    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);

    // R3: the caller gates pushes against a full queue.
    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R4: the caller gates pops against an empty queue.
    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/aud_status.sv
// Status word, sticky error flags and masked interrupt.
// Assumes thresholds are 4-bit and levels may reach DEPTH.
module aud_status #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [3:0]    tx_thr,
    input  logic [3:0]    rx_thr,
    input  logic          tx_full,
    input  logic          rx_empty,
    input  logic          link_on,
    input  logic          frame_active,
    input  logic          ur_evt,
    input  logic          ovr_evt,
    input  logic          clr_ur,
    input  logic          clr_ovr,
    input  logic          flush,
    input  logic [3:0]    irq_mask,
    output logic [7:0]    status,
    output logic          irq
);
    import aud_pkg::*;

    logic ur_q, ovr_q;

    // Sticky flags: flush wins, then a new event, then the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ur_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            ur_q  <= ur_evt  | (ur_q  & ~clr_ur);
            ovr_q <= ovr_evt | (ovr_q & ~clr_ovr);
        end
    end

    // Assemble the status word from queue state and engine state.
    always_comb begin
        status         = '0;
        status[ST_TNF] = ~tx_full;
        status[ST_RNE] = ~rx_empty;
        status[ST_BSY] = link_on & frame_active;
        status[ST_TRQ] = (tx_level <= LW'(tx_thr));
        status[ST_RRQ] = (rx_level >= LW'(rx_thr));
        status[ST_UR]  = ur_q;
        status[ST_OVR] = ovr_q;
        status[ST_OFF] = ~link_on & ~frame_active;
    end

    assign irq = |(status[6:3] & irq_mask);

    // R7: underrun stays set unless cleared or flushed.
    assert_ur_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_q && !clr_ur && !flush) |=> ur_q);
    // R8: an overrun event always raises the flag.
    assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !flush) |=> ovr_q);
    // R9: a clear never defeats a simultaneous underrun event.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_evt && clr_ur && !flush) |=> ur_q);
    // R12: no interrupt with every mask bit off.
    assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 4'b0) |-> !irq);
endmodule

// File: rtl/audio_port_ctrl.sv
// Register bank and queue controller of a stereo serial audio port.
// Assumes a single-cycle register port (one strobe per access) and an
// external shifting engine using pull/push strobes. Reads return data one
// edge after reg_rd; a data-port read pops the receive queue.
module audio_port_ctrl #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int DIV_W = 12,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic             tx_pull,
    output logic [W-1:0]     tx_word,
    input  logic             rx_push,
    input  logic [W-1:0]     rx_word,
    input  logic             frame_active,
    output logic             link_en,
    output logic             bclk_out_en,
    output logic             fmt_msb_just,
    output logic             rec_off,
    output logic             play_off,
    output logic             loopback,
    output logic [DIV_W-1:0] clk_div,
    output logic             irq
);
    import aud_pkg::*;

    logic [15:0]      ctrl_q;
    logic [5:0]       fmt_q;
    logic [6:0]       mask_q;
    logic [DIV_W-1:0] div_q;

    logic [W-1:0]  tx_head, rx_head;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic          ur_evt, ovr_evt, clr_ur, clr_ovr, flush;
    logic [7:0]    status;
    logic [W-1:0]  rd_mux;

    // Decode write and read strobes against the data port and clear register.
    always_comb begin
        flush      = ctrl_q[3];
        tx_push_ok = reg_wr && (reg_addr == OFF_DATA) && !tx_full;
        rx_pop_ok  = reg_rd && (reg_addr == OFF_DATA) && !rx_empty;
        tx_pop_ok  = tx_pull && !tx_empty;
        rx_push_ok = rx_push && !rx_full;
        ur_evt     = tx_pull && tx_empty;
        ovr_evt    = rx_push && rx_full;
        clr_ur     = reg_wr && (reg_addr == OFF_CLR) && reg_wdata[ST_UR];
        clr_ovr    = reg_wr && (reg_addr == OFF_CLR) && reg_wdata[ST_OVR];
    end

    // Configuration registers, masked to their defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            fmt_q  <= '0;
            mask_q <= '0;
            div_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFF_CTRL: ctrl_q <= reg_wdata[15:0] & CTRL_WMASK;
                OFF_FMT:  fmt_q  <= reg_wdata[5:0]  & FMT_WMASK;
                OFF_MASK: mask_q <= reg_wdata[6:0]  & MASK_WMASK;
                OFF_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    aud_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push_ok), .din(reg_wdata), .pop(tx_pop_ok),
        .dout(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    aud_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push_ok), .din(rx_word), .pop(rx_pop_ok),
        .dout(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    aud_status #(.LW(LW)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(ctrl_q[11:8]), .rx_thr(ctrl_q[15:12]),
        .tx_full(tx_full), .rx_empty(rx_empty),
        .link_on(ctrl_q[0]), .frame_active(frame_active),
        .ur_evt(ur_evt), .ovr_evt(ovr_evt),
        .clr_ur(clr_ur), .clr_ovr(clr_ovr), .flush(flush),
        .irq_mask(mask_q[6:3]), .status(status), .irq(irq)
    );

    // Read multiplexer over all registers.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            OFF_CTRL: rd_mux = W'(ctrl_q);
            OFF_FMT:  rd_mux = W'(fmt_q);
            OFF_STAT: rd_mux = W'(status);
            OFF_MASK: rd_mux = W'(mask_q);
            OFF_DIV:  rd_mux = W'(div_q);
            OFF_DATA: rd_mux = rx_empty ? '0 : rx_head;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign tx_word      = tx_empty ? '0 : tx_head;
    assign link_en      = ctrl_q[0];
    assign bclk_out_en  = ctrl_q[2];
    assign fmt_msb_just = fmt_q[0];
    assign rec_off      = fmt_q[3];
    assign play_off     = fmt_q[4];
    assign loopback     = fmt_q[5];
    assign clk_div      = div_q;

    // R10: one cycle of soft reset leaves both queues empty.
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0));
    // R8: a delivered word to a full receive queue does not change its level.
    assert_ovr_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !rx_pop_ok && !flush) |=> (rx_level == LW'(DEPTH)));
endmodule

// File: tb/sim_audio_port_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_audio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pull = 1'b0;
    logic [31:0] tx_word;
    logic        rx_push = 1'b0;
    logic [31:0] rx_word = '0;
    logic        frame_active = 1'b0;
    logic        link_en, bclk_out_en, fmt_msb_just, rec_off, play_off, loopback;
    logic [11:0] clk_div;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    audio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pull(tx_pull), .tx_word(tx_word), .rx_push(rx_push),
        .rx_word(rx_word), .frame_active(frame_active), .link_en(link_en),
        .bclk_out_en(bclk_out_en), .fmt_msb_just(fmt_msb_just),
        .rec_off(rec_off), .play_off(play_off), .loopback(loopback),
        .clk_div(clk_div), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All ops start just after a falling edge and end on one.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic pull(output logic [31:0] w);
        tx_pull = 1'b1;
        #1 w = tx_word;
        @(negedge clk);
        tx_pull = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        rx_push = 1'b1; rx_word = w;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h0C, v); chk("R1 status", v, 32'h99);
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h14, v); chk("R1 mask", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFF5); rd(8'h00, v); chk("R2 ctrl mask", v, 32'hFF05);
        chk("R13 link_en/bclk", {30'b0, link_en, bclk_out_en}, 32'h3);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 fmt mask", v, 32'h39);
        chk("R13 fmt outs", {28'b0, fmt_msb_just, rec_off, play_off, loopback}, 32'hF);
        wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, v); chk("R2 div mask", v, 32'hFFF);
        chk("R13 clk_div", {20'b0, clk_div}, 32'hFFF);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R2 clear reads 0", v, 0);
        wr(8'h00, 0); wr(8'h04, 0);
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R2 mask reg", v, 32'h78);
        chk("R12 irq with service bits", {31'b0, irq}, 1);
        wr(8'h14, 0);
        chk("R12 irq masked", {31'b0, irq}, 0);
    endtask

    task automatic t_tx;
        logic [31:0] v;
        wr(8'h00, 32'h0400);
        for (int i = 0; i < 5; i++) wr(8'h80, 32'hA0 + i);
        rd(8'h0C, v); chk("R5 level5 thr4 no request", v, 32'h91);
        pull(v); chk("R3 first word", v, 32'hA0);
        rd(8'h0C, v); chk("R5 level4 thr4 request", v, 32'h99);
        for (int i = 1; i < 5; i++) begin pull(v); chk("R3 order", v, 32'hA0 + i); end
        for (int i = 0; i < 17; i++) wr(8'h80, 32'hB00 + i);
        rd(8'h0C, v); chk("R3 full clears not-full", v, 32'h90);
        for (int i = 0; i < 16; i++) begin pull(v); chk("R3 drain order", v, 32'hB00 + i); end
        pull(v); chk("R7 empty pull word", v, 0);
        rd(8'h0C, v); chk("R7 underrun set", v, 32'hB9);
        wr(8'h18, 32'h40); rd(8'h0C, v); chk("R9 other bit no effect", v, 32'hB9);
        wr(8'h18, 32'h20); rd(8'h0C, v); chk("R9 underrun cleared", v, 32'h99);
    endtask

    task automatic t_rx;
        logic [31:0] v;
        wr(8'h00, 32'h3000);
        rd(8'h0C, v); chk("R6 empty below thr", v, 32'h89);
        for (int i = 0; i < 3; i++) push(32'hC0 + i);
        rd(8'h0C, v); chk("R6 level3 request", v, 32'h9B);
        for (int i = 0; i < 3; i++) begin rd(8'h80, v); chk("R4 rx order", v, 32'hC0 + i); end
        for (int i = 0; i < 17; i++) push(32'hD00 + i);
        rd(8'h0C, v); chk("R8 overrun set", v, 32'hDB);
        for (int i = 0; i < 16; i++) begin rd(8'h80, v); chk("R8 kept words", v, 32'hD00 + i); end
        rd(8'h80, v); chk("R4 empty read zero", v, 0);
        wr(8'h18, 32'h40); rd(8'h0C, v); chk("R9 overrun cleared", v, 32'h89);
        wr(8'h00, 0);
    endtask

    task automatic t_setwins;
        logic [31:0] v;
        reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h20; tx_pull = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_pull = 1'b0;
        rd(8'h0C, v); chk("R9 set wins over clear", v, 32'hB9);
        wr(8'h18, 32'h20);
    endtask

    task automatic t_flush;
        logic [31:0] v;
        pull(v);
        for (int i = 0; i < 3; i++) wr(8'h80, i);
        push(32'h55); push(32'h66);
        wr(8'h00, 32'h8); wr(8'h00, 0);
        rd(8'h0C, v); chk("R10 flushed status", v, 32'h99);
        pull(v); chk("R10 tx empty after flush", v, 0);
        wr(8'h18, 32'h20);
        rd(8'h80, v); chk("R10 rx empty after flush", v, 0);
    endtask

    task automatic t_busy_irq;
        logic [31:0] v;
        frame_active = 1'b1; wr(8'h00, 1);
        rd(8'h0C, v); chk("R11 busy", v, 32'h1D);
        wr(8'h00, 0);
        rd(8'h0C, v); chk("R11 finishing frame", v, 32'h19);
        frame_active = 1'b0;
        rd(8'h0C, v); chk("R11 off", v, 32'h99);
        wr(8'h14, 32'h20);
        chk("R12 no flag no irq", {31'b0, irq}, 0);
        pull(v);
        chk("R12 underrun irq", {31'b0, irq}, 1);
        wr(8'h18, 32'h20);
        chk("R12 irq drops", {31'b0, irq}, 0);
        wr(8'h14, 0);
    endtask

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_tx();
        t_rx();
        t_setwins();
        t_flush();
        t_busy_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule